// File: doc/BRIEF.md
# Receive Lane Polarity and Order Mapper

This block sits in a multi-lane PCI Express receive path. It is placed after per-lane symbol capture and before 8b/10b decode. On every clock it takes one raw 10-bit symbol from each of up to eight physical lanes, together with a valid flag. It corrects board-level wiring choices before any decoding takes place. It complements the symbols of lanes whose differential pair was swapped, and it can restore the lane order when the lanes reach the receiver reversed. It then presents only the lanes of the active link width, in logical order, after one register stage.

The link configuration consists of the width code, a polarity mask indexed by physical lane and a reversal enable. It is captured only while the link-reset input is held high. The captured values then stay fixed until the next link reset. This lets the training logic set the mapping while the link is down, and the mapping cannot change in the middle of traffic.

Top module: `lane_map_top`

## Requirements
- R1: While rst_ni is low, valid_o and sym_o are zero. The held configuration returns to width x1, an all-zero polarity mask and reversal off.
- R2: The configuration inputs are loaded at each rising clock edge where link_rst_i is high. A loaded value applies to symbols taken at later edges. At edges where link_rst_i is low, changes on width_i, pol_inv_i and rev_en_i have no effect on the output.
- R3: The width_i encoding is 2'b00 for x1, 2'b01 for x2, 2'b10 for x4 and 2'b11 for x8. For an N-lane link, output lanes N and above on sym_o read zero.
- R4: Bit p of pol_inv_i selects inversion for physical lane p. An inverted lane has all ten bits of its symbol complemented. Physical lane p occupies sym_i[10p+9:10p], and logical lane j occupies sym_o[10j+9:10j].
- R5: The polarity settings of the lanes are independent. Any mix of inverted and true lanes within one link is mapped lane by lane.
- R6: With reversal on and N greater than 1, logical lane j carries physical lane N-1-j. Physical lanes N and above never reach the output. With reversal off, logical lane j carries physical lane j.
- R7: At width x1, the reversal enable has no effect. Logical lane 0 always carries physical lane 0.
- R8: Polarity is applied before reordering. The mask bit used for a symbol is always that of its physical lane, whatever the reversal setting.
- R9: valid_o equals valid_i from the previous rising edge, and sym_o is the mapping of sym_i from that same edge.
- R10: A COM symbol 10'h17C received on an inverted lane as 10'h283 is output as 10'h17C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_rst_i | input | 1 | High while the link is down; enables configuration capture |
| width_i | input | 2 | Link width code |
| pol_inv_i | input | 8 | Polarity inversion mask per physical lane |
| rev_en_i | input | 1 | Lane order reversal enable |
| valid_i | input | 1 | Input symbols valid |
| sym_i | input | 80 | Raw symbols, physical lane p at bits 10p+9:10p |
| valid_o | output | 1 | Output symbols valid |
| sym_o | output | 80 | Mapped symbols, logical lane j at bits 10j+9:10j |

## Verification
The hardest case to reach is a mismatch between physical and logical indexing under a mixed polarity mask with reversal on. A fault there only shows when the mask is asymmetric and the width is above x1. To reach it, the stimulus reconfigures the link at random every few vectors, with random width, mask and reversal. The stimulus also adds directed cases at x8 and x4 with single-bit masks. A further case changes the configuration inputs while link reset is low, to show that the held mapping persists.

// File: rtl/lane_map_pkg.sv
package lane_map_pkg;
  localparam int unsigned MAX_LANES = 8;
  localparam int unsigned SYM_W     = 10;

  typedef enum logic [1:0] {
    WIDTH_X1 = 2'b00,
    WIDTH_X2 = 2'b01,
    WIDTH_X4 = 2'b10,
    WIDTH_X8 = 2'b11
  } width_e;

  typedef struct packed {
    width_e                 width;
    logic [MAX_LANES-1:0]   pol_inv;
    logic                   rev_en;
  } link_cfg_t;

  localparam link_cfg_t CFG_RESET = '{width: WIDTH_X1, pol_inv: '0, rev_en: 1'b0};
endpackage

// File: rtl/lane_map_cfg.sv
module lane_map_cfg
  import lane_map_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      link_rst_i,
  input  link_cfg_t cfg_i,
  output link_cfg_t cfg_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= CFG_RESET;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (link_rst_i) cfg_o <= cfg_i;
    end
  end

  // configuration frozen outside link reset
  assert_cfg_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(link_rst_i)) |-> $stable(cfg_o));
endmodule

// File: rtl/lane_map_pol.sv
module lane_map_pol #(
  parameter int unsigned LANES = 8,
  parameter int unsigned SYM_W = 10
) (
  input  logic [LANES-1:0][SYM_W-1:0] sym_i,
  input  logic [LANES-1:0]            inv_i,
  output logic [LANES-1:0][SYM_W-1:0] sym_o
);
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    assign sym_o[p] = sym_i[p] ^ {SYM_W{inv_i[p]}};
  end
endmodule

// File: rtl/lane_map_order.sv
module lane_map_order
  import lane_map_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned SYM_W = 10
) (
  input  logic [LANES-1:0][SYM_W-1:0] phys_i,
  input  width_e                      width_i,
  input  logic                        rev_en_i,
  output logic [LANES-1:0][SYM_W-1:0] log_o
);
  localparam int unsigned IDX_W = $clog2(LANES);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] n_lanes;
  assign n_lanes = CNT_W'(1) << width_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [CNT_W-1:0] J = CNT_W'(j);
    logic [CNT_W-1:0] src;
    always_comb begin
      src = J;
      if (rev_en_i && n_lanes > CNT_W'(1) && J < n_lanes) src = n_lanes - CNT_W'(1) - J;
      log_o[j] = (J < n_lanes) ? phys_i[src[IDX_W-1:0]] : '0;
    end
  end
endmodule

// File: rtl/lane_map_top.sv
module lane_map_top
  import lane_map_pkg::*;
#(
  parameter int unsigned LANES = MAX_LANES,
  parameter int unsigned SW    = SYM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_rst_i,
  input  logic [1:0]        width_i,
  input  logic [LANES-1:0]  pol_inv_i,
  input  logic              rev_en_i,
  input  logic              valid_i,
  input  logic [LANES*SW-1:0] sym_i,
  output logic              valid_o,
  output logic [LANES*SW-1:0] sym_o
);
  link_cfg_t cfg_in, cfg_q;
  logic [LANES-1:0][SW-1:0] phys_raw, phys_fix, logical;
  logic armed_q;

  assign cfg_in   = '{width: width_e'(width_i), pol_inv: pol_inv_i, rev_en: rev_en_i};
  assign phys_raw = sym_i;

  lane_map_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .link_rst_i (link_rst_i),
    .cfg_i      (cfg_in),
    .cfg_o      (cfg_q)
  );

  lane_map_pol #(.LANES(LANES), .SYM_W(SW)) u_pol (
    .sym_i (phys_raw),
    .inv_i (cfg_q.pol_inv),
    .sym_o (phys_fix)
  );

  lane_map_order #(.LANES(LANES), .SYM_W(SW)) u_order (
    .phys_i   (phys_fix),
    .width_i  (cfg_q.width),
    .rev_en_i (cfg_q.rev_en),
    .log_o    (logical)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sym_o   <= '0;
      armed_q <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sym_o   <= logical;
      armed_q <= 1'b1;
    end
  end

  assert_valid_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (valid_o == $past(valid_i)));

  // x1: lane 0 straight through after polarity, regardless of reversal
  assert_x1_no_reverse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(cfg_q.width) == WIDTH_X1) |->
      (sym_o[SW-1:0] == ($past(sym_i[SW-1:0]) ^ {SW{$past(cfg_q.pol_inv[0])}})));

  for (genvar j = 1; j < LANES; j++) begin : g_chk
    assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && (j >= (1 << $past(cfg_q.width)))) |-> (sym_o[j*SW +: SW] == '0));
  end

  // reversed: logical 0 comes from physical N-1 with that lane's polarity bit
  assert_rev_phys_pol_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(cfg_q.rev_en) && $past(cfg_q.width) == WIDTH_X8) |->
      (sym_o[SW-1:0] == ($past(sym_i[(LANES-1)*SW +: SW]) ^ {SW{$past(cfg_q.pol_inv[LANES-1])}})));
endmodule

// File: tb/sim_lane_map_top.sv
module sim_lane_map_top;
  localparam int L = 8;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_rst = 1'b0;
  logic [1:0] width = 2'b00;
  logic [L-1:0] pol = '0;
  logic rev = 1'b0;
  logic vld = 1'b0;
  logic [L*W-1:0] sym = '0;
  logic vld_o;
  logic [L*W-1:0] sym_o;

  int checks = 0;
  int fails = 0;
  logic [1:0] h_w = 2'b00;
  logic [L-1:0] h_p = '0;
  logic h_r = 1'b0;

  always #2 clk = ~clk;

  lane_map_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .link_rst_i(link_rst), .width_i(width),
    .pol_inv_i(pol), .rev_en_i(rev), .valid_i(vld), .sym_i(sym),
    .valid_o(vld_o), .sym_o(sym_o)
  );

  function automatic logic [L*W-1:0] model(input logic [L*W-1:0] s, input logic [1:0] w,
                                           input logic [L-1:0] p, input logic r);
    logic [L*W-1:0] o;
    int n;
    n = 1 << w;
    o = '0;
    for (int j = 0; j < n; j++) begin
      int src;
      src = (r && n > 1) ? n - 1 - j : j;
      o[j*W +: W] = s[src*W +: W] ^ {W{p[src]}};
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] w, input logic [L-1:0] p, input logic r);
    @(negedge clk);
    width = w; pol = p; rev = r; link_rst = 1'b1;
    @(negedge clk);
    link_rst = 1'b0;
    h_w = w; h_p = p; h_r = r;
  endtask

  // drive at negedge, check at next negedge
  task automatic apply(input string req, input logic v, input logic [L*W-1:0] s);
    sym = s; vld = v;
    @(negedge clk);
    checks++;
    if (vld_o !== v) begin
      fails++;
      $display("FAIL R9 valid act=%b exp=%b", vld_o, v);
    end
    check(req, sym_o, model(s, h_w, h_p, h_r));
  endtask

  function automatic logic [L*W-1:0] rnd_sym();
    logic [L*W-1:0] s;
    for (int i = 0; i < L; i++) s[i*W +: W] = W'($urandom);
    return s;
  endfunction

  initial begin
    #20000000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [L*W-1:0] lanes;
    void'($urandom(32'd1234));
    sym = {L{10'h3FF}}; vld = 1'b1;
    #9;
    checks++;
    if (vld_o !== 1'b0) begin fails++; $display("FAIL R1 valid act=%b exp=0", vld_o); end
    check("R1 data", sym_o, '0);
    @(negedge clk); rst_n = 1'b1;
    // reset config: x1, no inversion, no reversal
    apply("R1 cfg", 1'b1, rnd_sym());

    // R10: COM recovery on inverted lanes, x4, lanes 1 and 3 inverted
    configure(2'b10, 8'b0000_1010, 1'b0);
    lanes = {L{10'h17C}};
    lanes[1*W +: W] = 10'h283;
    lanes[3*W +: W] = 10'h283;
    apply("R10 com", 1'b1, lanes);
    check("R10 com value", sym_o[4*W-1:0], {4{10'h17C}});

    // R6 x4 reversal identifiable lanes
    configure(2'b10, 8'h00, 1'b1);
    for (int i = 0; i < L; i++) lanes[i*W +: W] = W'(i + 16);
    apply("R6 x4 rev", 1'b1, lanes);
    check("R6 order", sym_o[4*W-1:0], {10'd16, 10'd17, 10'd18, 10'd19});

    // R8 polarity follows physical lane under reversal, x8
    configure(2'b11, 8'b1000_0000, 1'b1);
    apply("R8 x8 rev pol", 1'b1, lanes);
    check("R8 lane0", {70'b0, sym_o[W-1:0]}, {70'b0, ~10'd23});

    // R7 reversal ignored at x1
    configure(2'b00, 8'b0000_0001, 1'b1);
    apply("R7 x1 rev", 1'b1, lanes);
    check("R7 lane0", sym_o, {70'b0, ~10'd16});

    // R3 x2 upper lanes zero
    configure(2'b01, 8'hFF, 1'b0);
    apply("R3 x2", 1'b0, rnd_sym());

    // R2 config change without link reset ignored
    @(negedge clk);
    width = 2'b11; pol = 8'h55; rev = 1'b1;
    apply("R2 ignored", 1'b1, rnd_sym());
    apply("R2 ignored 2", 1'b1, rnd_sym());

    // R4 R5 random mix
    for (int k = 0; k < 400; k++) begin
      if (k % 16 == 0)
        configure(2'($urandom), 8'($urandom), 1'($urandom));
      apply("R4 R5 R6 random", 1'($urandom), rnd_sym());
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule